// File: doc/BRIEF.md
# Micro-op Allocation Stage with Expansion

This stage sits between instruction decode and the reservation-station queues. Each cycle the decoder may offer a group of one or two micro-ops. The stage captures the group in a small hold register. It then writes operations into three target queues: integer, vector and memory. Each queue has a two-lane valid output and a single ready input. In the normal case both micro-ops of a group leave in one cycle, and a new group is taken in that same cycle, so two micro-ops per cycle are allocated back to back.

Two kinds of micro-op need special handling.

- **Complex micro-ops** (increment/decrement, pop, push, call, return, gather, three-source address) each become two execution operations. They use an allocation cycle on their own.
- **Load-op micro-ops** stay a single micro-op. That one micro-op is written, under the same tag, into the memory queue and into an execution queue.

A controller with three states orders the work:

- `S_EMPTY`: nothing is held.
- `S_PAIR`: the older micro-op, and possibly a younger one, is held.
- `S_LONE`: only the younger micro-op of a split group is left.

The transitions are named as follows:

- *load*: `S_EMPTY` to `S_PAIR`, when a group is taken.
- *stall*: any state stays where it is while a queue is not ready.
- *finish*: `S_PAIR` or `S_LONE` to `S_EMPTY`, when the held work issues and no new group arrives.
- *finish-and-load*: `S_PAIR` or `S_LONE` to `S_PAIR`, when the held work issues and a new group is taken in the same cycle.
- *defer*: `S_PAIR` to `S_LONE`, when a complex micro-op in either slot splits the group.

Top module: `alloc_stage`

## Requirements
- R1: During and right after a synchronous active-high reset, `dec_ready` is 1 and every queue valid bit is 0.
- R2: A group of two non-complex micro-ops issues in the cycle after it is taken. `dec_ready` is 1 in that issue cycle, so consecutive groups issue in consecutive cycles.
- R3: A simple micro-op (class 0) becomes one operation with code 0. Its queue is chosen by the unit code: unit 0 selects the integer queue, unit 1 the vector queue, unit 2 the memory queue, and unit 3 the integer queue.
- R4: A load-op micro-op (class 2) issues in one cycle as code 1 in the memory queue and as code 2 in the execution queue, both with its tag. The execution queue is the vector queue for unit 1 and the integer queue for any other unit.
- R5: A complex micro-op (class 1) issues two operations with its tag in one cycle. The first and second operations depend on the kind code:
  - kind 0: integer 3 then integer 4 (add, then flag merge).
  - kind 1: memory 5 and integer 7 (load, stack update).
  - kind 2: memory 6 and integer 7 (store, stack update).
  - kinds 3 and 4: integer 8 then integer 7 (jump, stack update).
  - kind 5: vector 9 then vector 10.
  - kinds 6 and 7: integer 11 then integer 12.
- R6: When a group of two holds a complex micro-op in either slot, the older micro-op issues first and the younger one issues in the following cycle. `dec_ready` is 0 in the first of these two cycles.
- R7: In any cycle that issues a complex operation (any code from 3 to 12), exactly two operations are valid across all queues.
- R8: While any of `int_ready`, `vec_ready` or `mem_ready` is 0, no queue valid bit is set. While held work is waiting, `dec_ready` is also 0. When all queues become ready, the waiting work issues unchanged.
- R9: Within a queue, lane 0 carries the older operation, and lane 1 is valid only when lane 0 is valid. Lane L carries its code in bits [4L+3:4L] and its tag in bits [8L+7:8L]. Invalid lanes show code 0 and tag 0.
- R10: Class codes 3 to 7 are handled exactly like class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoder offers a group |
| dec_two | input | 1 | Slot 1 of the group is valid |
| dec_ready | output | 1 | Group is taken this cycle if offered |
| dec0_cls | input | 3 | Slot 0 class code |
| dec0_unit | input | 2 | Slot 0 unit code |
| dec0_kind | input | 3 | Slot 0 complex kind |
| dec0_tag | input | TAG_W | Slot 0 tag |
| dec1_cls | input | 3 | Slot 1 class code |
| dec1_unit | input | 2 | Slot 1 unit code |
| dec1_kind | input | 3 | Slot 1 complex kind |
| dec1_tag | input | TAG_W | Slot 1 tag |
| int_valid | output | 2 | Integer queue lane valids |
| int_code | output | 8 | Integer queue lane codes |
| int_tag | output | 2*TAG_W | Integer queue lane tags |
| int_ready | input | 1 | Integer queue can take two operations |
| vec_valid | output | 2 | Vector queue lane valids |
| vec_code | output | 8 | Vector queue lane codes |
| vec_tag | output | 2*TAG_W | Vector queue lane tags |
| vec_ready | input | 1 | Vector queue can take two operations |
| mem_valid | output | 2 | Memory queue lane valids |
| mem_code | output | 8 | Memory queue lane codes |
| mem_tag | output | 2*TAG_W | Memory queue lane tags |
| mem_ready | input | 1 | Memory queue can take two operations |

## Verification
The controller state shows at the ports one cycle after a group is taken. A wrong state at that point appears as missing or duplicated operations, or as a `dec_ready` that fails to drop during a deferred group. A lost or repeated younger micro-op shows up in the cycle after the split. A wrong expansion shows up at once, as a wrong code or a wrong queue. A stall that leaks shows up as a valid bit while a ready input is low. A hold register that is overwritten during a stall shows up as a changed tag when the stall ends.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
    localparam int NUM_Q   = 3;
    localparam int LANES   = 2;
    localparam int SLOTS   = 2;
    localparam int NUM_OPS = SLOTS * 2;
    localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int QI_INT  = 0;
    localparam int QI_VEC  = 1;
    localparam int QI_MEM  = 2;

    localparam logic [2:0] CLS_COMPLEX = 3'd1;
    localparam logic [2:0] CLS_LOADOP  = 3'd2;

    typedef enum logic [1:0] {Q_INT = 2'd0, Q_VEC = 2'd1, Q_MEM = 2'd2, Q_NONE = 2'd3} qsel_t;

    typedef enum logic [3:0] {
        OP_PASS    = 4'd0,
        OP_LDOP_M  = 4'd1,
        OP_LDOP_X  = 4'd2,
        OP_ADD     = 4'd3,
        OP_FLAGMRG = 4'd4,
        OP_LOAD    = 4'd5,
        OP_STORE   = 4'd6,
        OP_SPUPD   = 4'd7,
        OP_JUMP    = 4'd8,
        OP_GATH_A  = 4'd9,
        OP_GATH_B  = 4'd10,
        OP_AGU_A   = 4'd11,
        OP_AGU_B   = 4'd12
    } opc_t;

    typedef struct packed {
        logic [2:0] cls;
        logic [1:0] unit;
        logic [2:0] kind;
    } uop_ctl_t;

    typedef struct packed {
        logic  vld;
        qsel_t q;
        opc_t  opc;
    } eop_t;

    typedef enum logic [1:0] {S_EMPTY = 2'd0, S_PAIR = 2'd1, S_LONE = 2'd2} alloc_state_t;
endpackage

// File: rtl/alloc_expand.sv
module alloc_expand
    import alloc_pkg::*;
(
    input  uop_ctl_t ctl,
    output eop_t     op_a,
    output eop_t     op_b,
    output logic     is_cplx
);
    function automatic qsel_t unit_queue(input logic [1:0] u);
        case (u)
            2'd1:    return Q_VEC;
            2'd2:    return Q_MEM;
            default: return Q_INT;
        endcase
    endfunction

    function automatic qsel_t exec_queue(input logic [1:0] u);
        return (u == 2'd1) ? Q_VEC : Q_INT;
    endfunction

    always_comb begin
        is_cplx = (ctl.cls == CLS_COMPLEX);
        op_a    = '{vld: 1'b1, q: unit_queue(ctl.unit), opc: OP_PASS};
        op_b    = '{vld: 1'b0, q: Q_INT, opc: OP_PASS};
        if (is_cplx) begin
            op_b.vld = 1'b1;
            case (ctl.kind)
                3'd0: begin
                    op_a.q = Q_INT; op_a.opc = OP_ADD;
                    op_b.q = Q_INT; op_b.opc = OP_FLAGMRG;
                end
                3'd1: begin
                    op_a.q = Q_MEM; op_a.opc = OP_LOAD;
                    op_b.q = Q_INT; op_b.opc = OP_SPUPD;
                end
                3'd2: begin
                    op_a.q = Q_MEM; op_a.opc = OP_STORE;
                    op_b.q = Q_INT; op_b.opc = OP_SPUPD;
                end
                3'd3, 3'd4: begin
                    op_a.q = Q_INT; op_a.opc = OP_JUMP;
                    op_b.q = Q_INT; op_b.opc = OP_SPUPD;
                end
                3'd5: begin
                    op_a.q = Q_VEC; op_a.opc = OP_GATH_A;
                    op_b.q = Q_VEC; op_b.opc = OP_GATH_B;
                end
                default: begin
                    op_a.q = Q_INT; op_a.opc = OP_AGU_A;
                    op_b.q = Q_INT; op_b.opc = OP_AGU_B;
                end
            endcase
        end else if (ctl.cls == CLS_LOADOP) begin
            op_a.q   = Q_MEM;
            op_a.opc = OP_LDOP_M;
            op_b.vld = 1'b1;
            op_b.q   = exec_queue(ctl.unit);
            op_b.opc = OP_LDOP_X;
        end
    end
endmodule

// File: rtl/alloc_hold.sv
module alloc_hold
    import alloc_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic             dec_two,
    input  uop_ctl_t         in_ctl [SLOTS],
    input  logic [TAG_W-1:0] in_tag [SLOTS],
    input  logic             all_ready,
    input  logic             cplx_a,
    input  logic             cplx_b,
    output uop_ctl_t         cur_ctl [SLOTS],
    output logic [TAG_W-1:0] cur_tag [SLOTS],
    output logic [SLOTS-1:0] issue,
    output logic             fire,
    output logic             dec_ready
);
    alloc_state_t     state, state_nx;
    uop_ctl_t         h_ctl [SLOTS];
    logic [TAG_W-1:0] h_tag [SLOTS];
    logic             h1_vld;
    logic             busy, done, take;

    // state register and hold registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_EMPTY;
            h1_vld <= 1'b0;
            for (int s = 0; s < SLOTS; s++) begin
                h_ctl[s] <= '0;
                h_tag[s] <= '0;
            end
        end else begin
            state <= state_nx;
            if (take) begin
                h1_vld <= dec_two;
                for (int s = 0; s < SLOTS; s++) begin
                    h_ctl[s] <= in_ctl[s];
                    h_tag[s] <= in_tag[s];
                end
            end
        end
    end

    // outputs of the current state
    always_comb begin
        busy       = 1'b0;
        done       = 1'b1;
        issue      = '0;
        cur_ctl[0] = h_ctl[0];
        cur_tag[0] = h_tag[0];
        cur_ctl[1] = h_ctl[1];
        cur_tag[1] = h_tag[1];
        unique case (state)
            S_EMPTY: begin
                busy = 1'b0;
            end
            S_PAIR: begin
                busy     = 1'b1;
                issue[0] = 1'b1;
                issue[1] = h1_vld && !cplx_a && !cplx_b;
                done     = !h1_vld || issue[1];
            end
            S_LONE: begin
                busy       = 1'b1;
                issue[0]   = 1'b1;
                cur_ctl[0] = h_ctl[1];
                cur_tag[0] = h_tag[1];
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        fire      = busy && all_ready;
        dec_ready = !busy || (fire && done);
        take      = dec_valid && dec_ready;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_EMPTY: if (take) state_nx = S_PAIR;
            S_PAIR: begin
                if (fire) begin
                    if (!done)     state_nx = S_LONE;
                    else if (take) state_nx = S_PAIR;
                    else           state_nx = S_EMPTY;
                end
            end
            S_LONE: if (fire) state_nx = take ? S_PAIR : S_EMPTY;
            default: state_nx = S_EMPTY;
        endcase
    end
endmodule

// File: rtl/alloc_router.sv
module alloc_router
    import alloc_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             fire,
    input  eop_t             ops   [NUM_OPS],
    input  logic [TAG_W-1:0] tags  [NUM_OPS],
    output logic             q_vld [NUM_Q][LANES],
    output opc_t             q_opc [NUM_Q][LANES],
    output logic [TAG_W-1:0] q_tag [NUM_Q][LANES]
);
    logic [LANE_W:0] fill [NUM_Q];

    always_comb begin
        for (int k = 0; k < NUM_Q; k++) begin
            fill[k] = '0;
            for (int l = 0; l < LANES; l++) begin
                q_vld[k][l] = 1'b0;
                q_opc[k][l] = OP_PASS;
                q_tag[k][l] = '0;
            end
        end
        for (int i = 0; i < NUM_OPS; i++) begin
            for (int k = 0; k < NUM_Q; k++) begin
                if (fire && ops[i].vld && (int'(ops[i].q) == k) && (int'(fill[k]) < LANES)) begin
                    q_vld[k][fill[k][LANE_W-1:0]] = 1'b1;
                    q_opc[k][fill[k][LANE_W-1:0]] = ops[i].opc;
                    q_tag[k][fill[k][LANE_W-1:0]] = tags[i];
                    fill[k] = fill[k] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/alloc_stage.sv
module alloc_stage
    import alloc_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dec_valid,
    input  logic                   dec_two,
    output logic                   dec_ready,
    input  logic [2:0]             dec0_cls,
    input  logic [1:0]             dec0_unit,
    input  logic [2:0]             dec0_kind,
    input  logic [TAG_W-1:0]       dec0_tag,
    input  logic [2:0]             dec1_cls,
    input  logic [1:0]             dec1_unit,
    input  logic [2:0]             dec1_kind,
    input  logic [TAG_W-1:0]       dec1_tag,
    output logic [LANES-1:0]       int_valid,
    output logic [4*LANES-1:0]     int_code,
    output logic [TAG_W*LANES-1:0] int_tag,
    input  logic                   int_ready,
    output logic [LANES-1:0]       vec_valid,
    output logic [4*LANES-1:0]     vec_code,
    output logic [TAG_W*LANES-1:0] vec_tag,
    input  logic                   vec_ready,
    output logic [LANES-1:0]       mem_valid,
    output logic [4*LANES-1:0]     mem_code,
    output logic [TAG_W*LANES-1:0] mem_tag,
    input  logic                   mem_ready
);
    uop_ctl_t         in_ctl  [SLOTS];
    logic [TAG_W-1:0] in_tag  [SLOTS];
    uop_ctl_t         cur_ctl [SLOTS];
    logic [TAG_W-1:0] cur_tag [SLOTS];
    logic [SLOTS-1:0] issue;
    logic [SLOTS-1:0] cplx;
    logic             fire;
    eop_t             xa [SLOTS];
    eop_t             xb [SLOTS];
    eop_t             ops  [NUM_OPS];
    logic [TAG_W-1:0] tags [NUM_OPS];
    logic             q_vld [NUM_Q][LANES];
    opc_t             q_opc [NUM_Q][LANES];
    logic [TAG_W-1:0] q_tag [NUM_Q][LANES];

    assign in_ctl[0] = '{cls: dec0_cls, unit: dec0_unit, kind: dec0_kind};
    assign in_ctl[1] = '{cls: dec1_cls, unit: dec1_unit, kind: dec1_kind};
    assign in_tag[0] = dec0_tag;
    assign in_tag[1] = dec1_tag;

    alloc_hold #(.TAG_W(TAG_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_two   (dec_two),
        .in_ctl    (in_ctl),
        .in_tag    (in_tag),
        .all_ready (int_ready && vec_ready && mem_ready),
        .cplx_a    (cplx[0]),
        .cplx_b    (cplx[1]),
        .cur_ctl   (cur_ctl),
        .cur_tag   (cur_tag),
        .issue     (issue),
        .fire      (fire),
        .dec_ready (dec_ready)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        alloc_expand u_exp (
            .ctl     (cur_ctl[s]),
            .op_a    (xa[s]),
            .op_b    (xb[s]),
            .is_cplx (cplx[s])
        );
        always_comb begin
            ops[2*s]       = xa[s];
            ops[2*s].vld   = xa[s].vld && issue[s];
            ops[2*s+1]     = xb[s];
            ops[2*s+1].vld = xb[s].vld && issue[s];
            tags[2*s]      = cur_tag[s];
            tags[2*s+1]    = cur_tag[s];
        end
    end

    alloc_router #(.TAG_W(TAG_W)) u_route (
        .fire  (fire),
        .ops   (ops),
        .tags  (tags),
        .q_vld (q_vld),
        .q_opc (q_opc),
        .q_tag (q_tag)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign int_valid[l]              = q_vld[QI_INT][l];
        assign int_code[4*l +: 4]        = q_opc[QI_INT][l];
        assign int_tag[TAG_W*l +: TAG_W] = q_tag[QI_INT][l];
        assign vec_valid[l]              = q_vld[QI_VEC][l];
        assign vec_code[4*l +: 4]        = q_opc[QI_VEC][l];
        assign vec_tag[TAG_W*l +: TAG_W] = q_tag[QI_VEC][l];
        assign mem_valid[l]              = q_vld[QI_MEM][l];
        assign mem_code[4*l +: 4]        = q_opc[QI_MEM][l];
        assign mem_tag[TAG_W*l +: TAG_W] = q_tag[QI_MEM][l];
    end
endmodule

// File: rtl/alloc_stage_chk.sv
module alloc_stage_chk (
    input logic       clk,
    input logic       rst,
    input logic       dec_ready,
    input logic [1:0] int_valid,
    input logic [7:0] int_code,
    input logic       int_ready,
    input logic [1:0] vec_valid,
    input logic [7:0] vec_code,
    input logic       vec_ready,
    input logic [1:0] mem_valid,
    input logic [7:0] mem_code,
    input logic       mem_ready
);
    logic [2:0] n_total, n_ldm, n_ldx;
    logic       has_cplx, none_valid, all_rdy;

    always_comb begin
        n_total  = 3'(int_valid[0]) + 3'(int_valid[1]) + 3'(vec_valid[0])
                 + 3'(vec_valid[1]) + 3'(mem_valid[0]) + 3'(mem_valid[1]);
        n_ldm    = '0;
        n_ldx    = '0;
        has_cplx = 1'b0;
        for (int l = 0; l < 2; l++) begin
            if (mem_valid[l] && mem_code[4*l +: 4] == 4'd1) n_ldm = n_ldm + 3'd1;
            if (int_valid[l] && int_code[4*l +: 4] == 4'd2) n_ldx = n_ldx + 3'd1;
            if (vec_valid[l] && vec_code[4*l +: 4] == 4'd2) n_ldx = n_ldx + 3'd1;
            if (int_valid[l] && int_code[4*l +: 4] >= 4'd3) has_cplx = 1'b1;
            if (vec_valid[l] && vec_code[4*l +: 4] >= 4'd3) has_cplx = 1'b1;
            if (mem_valid[l] && mem_code[4*l +: 4] >= 4'd3) has_cplx = 1'b1;
        end
        none_valid = (int_valid == 2'b00) && (vec_valid == 2'b00) && (mem_valid == 2'b00);
        all_rdy    = int_ready && vec_ready && mem_ready;
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (dec_ready && none_valid))
        else $error("reset state not idle");
    p_lane_order_r9: assert property (@(posedge clk) disable iff (rst)
        (!int_valid[1] || int_valid[0]) && (!vec_valid[1] || vec_valid[0]) && (!mem_valid[1] || mem_valid[0]))
        else $error("lane 1 valid without lane 0");
    p_stall_quiet_r8: assert property (@(posedge clk) disable iff (rst) !all_rdy |-> none_valid)
        else $error("operation issued during backpressure");
    p_ldop_split_r4: assert property (@(posedge clk) disable iff (rst) n_ldm == n_ldx)
        else $error("load-op halves not issued together");
    p_cplx_alone_r7: assert property (@(posedge clk) disable iff (rst) has_cplx |-> (n_total == 3'd2))
        else $error("complex expansion shares its cycle");
endmodule

bind alloc_stage alloc_stage_chk u_chk (.*);

// File: tb/tb_alloc_stage.sv
module tb_alloc_stage;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] K_PASS = 4'd0, K_LDM = 4'd1, K_LDX = 4'd2, K_ADD = 4'd3,
                           K_FLG = 4'd4, K_LD = 4'd5, K_ST = 4'd6, K_SP = 4'd7,
                           K_JMP = 4'd8, K_GA = 4'd9, K_GB = 4'd10, K_AA = 4'd11, K_AB = 4'd12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_valid = 1'b0, dec_two = 1'b0, dec_ready;
    logic [2:0] dec0_cls = '0, dec1_cls = '0, dec0_kind = '0, dec1_kind = '0;
    logic [1:0] dec0_unit = '0, dec1_unit = '0;
    logic [7:0] dec0_tag = '0, dec1_tag = '0;
    logic [1:0] int_valid, vec_valid, mem_valid;
    logic [7:0] int_code, vec_code, mem_code;
    logic [15:0] int_tag, vec_tag, mem_tag;
    logic int_ready = 1'b1, vec_ready = 1'b1, mem_ready = 1'b1;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alloc_stage dut (.*);

    function automatic logic [31:0] qx(input logic [1:0] v, input logic [3:0] c0, input logic [7:0] t0,
                                       input logic [3:0] c1, input logic [7:0] t1);
        return {6'd0, v, c1, c0, t1, t0};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_q(input string req, input logic [31:0] ei, input logic [31:0] ev, input logic [31:0] em);
        chk(req, "int queue", {6'd0, int_valid, int_code, int_tag}, ei);
        chk(req, "vec queue", {6'd0, vec_valid, vec_code, vec_tag}, ev);
        chk(req, "mem queue", {6'd0, mem_valid, mem_code, mem_tag}, em);
    endtask

    task automatic chk_rdy(input string req, input logic exp);
        chk(req, "dec_ready", {31'd0, dec_ready}, {31'd0, exp});
    endtask

    task automatic slot(input int s, input logic [2:0] c, input logic [1:0] u, input logic [2:0] k, input logic [7:0] t);
        if (s == 0) begin dec0_cls = c; dec0_unit = u; dec0_kind = k; dec0_tag = t; end
        else        begin dec1_cls = c; dec1_unit = u; dec1_kind = k; dec1_tag = t; end
    endtask

    task automatic offer(input logic two);
        dec_valid = 1'b1;
        dec_two   = two;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        step(); #1;
        chk_rdy("R1", 1'b1);
        chk_q("R1", 0, 0, 0);
        rst = 1'b0;
        step(); #1;
        chk_rdy("R1", 1'b1);
        chk_q("R1", 0, 0, 0);
    endtask

    // R3 R2: simple pair into two queues
    task automatic t_simple_pair();
        slot(0, 3'd0, 2'd0, 3'd0, 8'h11);
        slot(1, 3'd0, 2'd1, 3'd0, 8'h12);
        offer(1'b1);
        step(); dec_valid = 1'b0; #1;
        chk_q("R3", qx(2'b01, K_PASS, 8'h11, 0, 0), qx(2'b01, K_PASS, 8'h12, 0, 0), 0);
        chk_rdy("R2", 1'b1);
        step(); #1;
        chk_q("R2", 0, 0, 0);
        slot(0, 3'd0, 2'd2, 3'd0, 8'h13);
        offer(1'b0);
        step(); dec_valid = 1'b0; #1;
        chk_q("R3", 0, 0, qx(2'b01, K_PASS, 8'h13, 0, 0));
        step();
    endtask

    // R2 R9: back-to-back groups, lane order
    task automatic t_back_to_back();
        slot(0, 3'd0, 2'd0, 3'd0, 8'h31);
        slot(1, 3'd0, 2'd0, 3'd0, 8'h32);
        offer(1'b1);
        step();
        slot(0, 3'd0, 2'd1, 3'd0, 8'h33);
        slot(1, 3'd0, 2'd1, 3'd0, 8'h34);
        #1;
        chk_q("R9", qx(2'b11, K_PASS, 8'h31, K_PASS, 8'h32), 0, 0);
        chk_rdy("R2", 1'b1);
        step(); dec_valid = 1'b0; #1;
        chk_q("R2", 0, qx(2'b11, K_PASS, 8'h33, K_PASS, 8'h34), 0);
        step(); #1;
        chk_q("R2", 0, 0, 0);
    endtask

    // R4: load-op split, two load-ops in one group
    task automatic t_loadop();
        slot(0, 3'd2, 2'd1, 3'd0, 8'h21);
        slot(1, 3'd0, 2'd2, 3'd0, 8'h22);
        offer(1'b1);
        step(); dec_valid = 1'b0; #1;
        chk_q("R4", 0, qx(2'b01, K_LDX, 8'h21, 0, 0), qx(2'b11, K_LDM, 8'h21, K_PASS, 8'h22));
        step();
        slot(0, 3'd2, 2'd0, 3'd0, 8'h51);
        slot(1, 3'd2, 2'd3, 3'd0, 8'h52);
        offer(1'b1);
        step(); dec_valid = 1'b0; #1;
        chk_q("R4", qx(2'b11, K_LDX, 8'h51, K_LDX, 8'h52), 0, qx(2'b11, K_LDM, 8'h51, K_LDM, 8'h52));
        chk_rdy("R4", 1'b1);
        step();
    endtask

    // R5 R6 R7: complex in slot 0 followed by a simple
    task automatic t_cplx_first();
        slot(0, 3'd1, 2'd0, 3'd0, 8'h41);
        slot(1, 3'd0, 2'd0, 3'd0, 8'h42);
        offer(1'b1);
        step(); dec_valid = 1'b0; #1;
        chk_q("R7", qx(2'b11, K_ADD, 8'h41, K_FLG, 8'h41), 0, 0);
        chk_rdy("R6", 1'b0);
        step(); #1;
        chk_q("R6", qx(2'b01, K_PASS, 8'h42, 0, 0), 0, 0);
        chk_rdy("R6", 1'b1);
        step(); #1;
        chk_q("R6", 0, 0, 0);
    endtask

    // R6: complex in slot 1 is deferred
    task automatic t_cplx_second();
        slot(0, 3'd0, 2'd0, 3'd0, 8'h61);
        slot(1, 3'd1, 2'd0, 3'd1, 8'h62);
        offer(1'b1);
        step(); dec_valid = 1'b0; #1;
        chk_q("R6", qx(2'b01, K_PASS, 8'h61, 0, 0), 0, 0);
        chk_rdy("R6", 1'b0);
        step(); #1;
        chk_q("R6", qx(2'b01, K_SP, 8'h62, 0, 0), 0, qx(2'b01, K_LD, 8'h62, 0, 0));
        step(); #1;
        chk_q("R6", 0, 0, 0);
    endtask

    // R5: every complex kind, alone
    task automatic t_kinds();
        for (int k = 0; k < 8; k++) begin
            logic [31:0] ei, ev, em;
            logic [7:0] t;
            t  = 8'h70 + 8'(k);
            ei = 0; ev = 0; em = 0;
            case (k)
                0:       ei = qx(2'b11, K_ADD, t, K_FLG, t);
                1:       begin ei = qx(2'b01, K_SP, t, 0, 0); em = qx(2'b01, K_LD, t, 0, 0); end
                2:       begin ei = qx(2'b01, K_SP, t, 0, 0); em = qx(2'b01, K_ST, t, 0, 0); end
                3, 4:    ei = qx(2'b11, K_JMP, t, K_SP, t);
                5:       ev = qx(2'b11, K_GA, t, K_GB, t);
                default: ei = qx(2'b11, K_AA, t, K_AB, t);
            endcase
            slot(0, 3'd1, 2'd2, 3'(k), t);
            offer(1'b0);
            step(); dec_valid = 1'b0; #1;
            chk_q("R5", ei, ev, em);
            step();
        end
    endtask

    // R8: backpressure holds the group
    task automatic t_stall();
        mem_ready = 1'b0;
        slot(0, 3'd0, 2'd0, 3'd0, 8'h81);
        slot(1, 3'd2, 2'd0, 3'd0, 8'h82);
        offer(1'b1);
        step();
        slot(0, 3'd0, 2'd0, 3'd0, 8'hEE);
        slot(1, 3'd0, 2'd0, 3'd0, 8'hEF);
        #1;
        chk_q("R8", 0, 0, 0);
        chk_rdy("R8", 1'b0);
        step(); #1;
        chk_q("R8", 0, 0, 0);
        chk_rdy("R8", 1'b0);
        dec_valid = 1'b0;
        mem_ready = 1'b1;
        #1;
        chk_q("R8", qx(2'b11, K_PASS, 8'h81, K_LDX, 8'h82), 0, qx(2'b01, K_LDM, 8'h82, 0, 0));
        step(); #1;
        chk_q("R8", 0, 0, 0);
        vec_ready = 1'b0;
        slot(0, 3'd0, 2'd0, 3'd0, 8'h83);
        offer(1'b0);
        step(); dec_valid = 1'b0; #1;
        chk_q("R8", 0, 0, 0);
        vec_ready = 1'b1; #1;
        chk_q("R8", qx(2'b01, K_PASS, 8'h83, 0, 0), 0, 0);
        step();
    endtask

    // R10: reserved class codes act as simple
    task automatic t_reserved();
        slot(0, 3'd5, 2'd3, 3'd0, 8'h91);
        slot(1, 3'd7, 2'd1, 3'd5, 8'h92);
        offer(1'b1);
        step(); dec_valid = 1'b0; #1;
        chk_q("R10", qx(2'b01, K_PASS, 8'h91, 0, 0), qx(2'b01, K_PASS, 8'h92, 0, 0), 0);
        chk_rdy("R10", 1'b1);
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_simple_pair();
        t_back_to_back();
        t_loadop();
        t_cplx_first();
        t_cplx_second();
        t_kinds();
        t_stall();
        t_reserved();
        step();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule